// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block sits between the two programmable dividers of a frequency synthesizer and the analog charge pump. It watches the divided reference clock and the divided feedback clock, both sampled on a fast system clock. A rising edge on each input arms its own side of the detector. Once both sides are armed they hold together for a short, fixed number of system-clock cycles and then clear. This overlap guarantees that the pump always receives a pulse of at least that width on both sides, even when the loop is perfectly aligned.

A polarity control suits the detector to oscillators whose frequency rises or falls with tuning voltage by exchanging the two pump commands. A three-state control, and the counter-reset control that also implies it, silence the pump. The counter-reset control additionally clears the detector and the lock state. A lock indicator is raised after a run of narrow comparisons. While the loop stays locked it sits high and drops low only during the brief overlap pulses. All pins are plain control and status signals, so there is no flow control at the edge of the block.

Top module: `pfd_lock_top`

## Requirements
- R1: With `pol_pos`=1 and the pump enabled, a rising edge of `ref_in` (low in one system cycle, high in the next) makes `up` high from the following clock edge onward, while `dn` stays low until the feedback side is armed.
- R2: With `pol_pos`=1 and the pump enabled, a rising edge of `fb_in` makes `dn` high from the following clock edge onward.
- R3: Once both sides are armed, both stay high for exactly `DLY` system cycles (default 2) and then both read low together. An input edge that arrives in the clearing cycle is lost.
- R4: With `pol_pos`=0 the commands are exchanged: a reference edge drives `dn` and a feedback edge drives `up`.
- R5: While `tri_force`=1, `up`, `dn` and `pump_en` all read 0. The detector keeps running underneath.
- R6: While `cnt_rst`=1, the pump is three-stated as in R5, both sides are held clear, and the lock state is cleared. An edge seen during reset does not arm a side after release.
- R7: A comparison ends when both sides clear. It counts as narrow when the pump was active (either side high) for at most `WTH` cycles (default 4). `lock` rises after `LOCK_N` (default 4) consecutive narrow comparisons.
- R8: While locked, `lock` reads 0 in exactly the cycles in which either side is armed, and 1 otherwise.
- R9: As soon as one pump pulse stays active for `WTH`+1 cycles, the lock state and the run count are cleared.
- R10: After `rst_n` is asserted, `up`, `dn` and `lock` are 0 and `pump_en` equals NOT(`tri_force` OR `cnt_rst`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both divided clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Divided reference clock |
| fb_in | input | 1 | Divided feedback clock |
| pol_pos | input | 1 | 1: positive tuning slope, 0: commands exchanged |
| tri_force | input | 1 | 1: three-state the pump |
| cnt_rst | input | 1 | 1: hold detector and lock clear, pump three-stated |
| up | output | 1 | Pump-up command |
| dn | output | 1 | Pump-down command |
| pump_en | output | 1 | 1 when the pump may drive |
| lock | output | 1 | Lock indicator, high with narrow low pulses when locked |

## Verification
The detector is driven with coincident edges, with reference-leading edges and with feedback-leading edges at lags of 1, 2 and 3 cycles. Together these separate the fixed overlap width from the lag-dependent lead width, and place a pulse exactly at the narrow/wide threshold and one cycle beyond it. The same edges are repeated with the polarity reversed, so that an exchange error shows up on the opposite output. Edges are also applied under three-state and under counter reset, which separates output gating that leaves the detector running from a reset that clears detector and lock. Runs of narrow comparisons just short of and at the lock count show when lock is declared, and the low gaps during later pulses show the locked waveform.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;

  // Exchange the two commands for a negative tuning slope.
  function automatic pump_t orient(pump_t raw, logic pos);
    pump_t o;
    o.up = pos ? raw.up : raw.dn;
    o.dn = pos ? raw.dn : raw.up;
    return o;
  endfunction
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int DLY = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  rise_ref,
  input  logic  rise_fb,
  output pump_t raw,
  output logic  clr_evt
);
  localparam int DCW = $clog2(DLY + 1);

  logic [DCW-1:0] dcnt_q;
  logic           both;

  assign both    = raw.up & raw.dn;
  assign clr_evt = both && (dcnt_q == DCW'(DLY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw    <= '0;
      dcnt_q <= '0;
    end else if (hold || clr_evt) begin
      raw    <= '0;
      dcnt_q <= '0;
    end else begin
      raw.up <= raw.up | rise_ref;
      raw.dn <= raw.dn | rise_fb;
      dcnt_q <= both ? dcnt_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet #(
  parameter int WTH    = 4,
  parameter int LOCK_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic active,
  input  logic clr_evt,
  output logic lock
);
  localparam int WW = $clog2(WTH + 2);
  localparam int GW = $clog2(LOCK_N + 1);

  logic [WW-1:0] wcnt_q;
  logic [GW-1:0] gcnt_q;
  logic          locked_q;
  logic          wide;
  logic          narrow;

  assign wide   = active && (wcnt_q >= WW'(WTH));
  assign narrow = clr_evt && (wcnt_q < WW'(WTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q   <= '0;
      gcnt_q   <= '0;
      locked_q <= 1'b0;
    end else if (hold) begin
      wcnt_q   <= '0;
      gcnt_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (clr_evt || !active)              wcnt_q <= '0;
      else if (wcnt_q != WW'(WTH + 1))     wcnt_q <= wcnt_q + 1'b1;

      if (wide) begin
        gcnt_q   <= '0;
        locked_q <= 1'b0;
      end else if (narrow) begin
        if (gcnt_q != GW'(LOCK_N)) gcnt_q <= gcnt_q + 1'b1;
        if (gcnt_q >= GW'(LOCK_N - 1)) locked_q <= 1'b1;
      end
    end
  end

  assign lock = locked_q & ~active;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int DLY    = 2,
  parameter int WTH    = 4,
  parameter int LOCK_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  input  logic pol_pos,
  input  logic tri_force,
  input  logic cnt_rst,
  output logic up,
  output logic dn,
  output logic pump_en,
  output logic lock
);
  localparam int NIN = 2;

  logic [NIN-1:0] clk_in;
  logic [NIN-1:0] rise;
  pump_t          raw;
  pump_t          shown;
  logic           clr_evt;
  logic           off;

  assign clk_in = {fb_in, ref_in};

  for (genvar i = 0; i < NIN; i++) begin : g_edge
    pfd_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (clk_in[i]),
      .rise (rise[i])
    );
  end

  pfd_core #(.DLY(DLY)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (cnt_rst),
    .rise_ref(rise[0]),
    .rise_fb (rise[1]),
    .raw     (raw),
    .clr_evt (clr_evt)
  );

  pfd_lockdet #(.WTH(WTH), .LOCK_N(LOCK_N)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (cnt_rst),
    .active (raw.up | raw.dn),
    .clr_evt(clr_evt),
    .lock   (lock)
  );

  assign off     = tri_force | cnt_rst;
  assign shown   = orient(raw, pol_pos);
  assign up      = ~off & shown.up;
  assign dn      = ~off & shown.dn;
  assign pump_en = ~off;
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
  parameter int DLY = 2
) (
  input logic clk,
  input logic rst_n,
  input logic tri_force,
  input logic cnt_rst,
  input logic up,
  input logic dn,
  input logic pump_en,
  input logic lock
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (up && dn) run_q <= (run_q == 16'hFFFF) ? run_q : run_q + 1'b1;
    else               run_q <= '0;
  end

  // R3
  overlap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |-> (run_q < 16'(DLY)));

  // R5
  tristate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_force || cnt_rst) |-> (!up && !dn && !pump_en));

  // R6
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> (!lock && !up && !dn));

  // R8
  lock_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (!up && !dn));

  // R10
  enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pump_en) |-> (tri_force || cnt_rst));
endmodule

bind pfd_lock_top pfd_lock_chk #(.DLY(DLY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tri_force(tri_force),
  .cnt_rst  (cnt_rst),
  .up       (up),
  .dn       (dn),
  .pump_en  (pump_en),
  .lock     (lock)
);

// File: tb/sim_pfd_lock_top.sv
`timescale 1ns/1ps
module sim_pfd_lock_top;
  localparam int DLY = 2;
  localparam int WTH = 4;
  localparam int LN  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, fb_in = 1'b0, pol_pos = 1'b1, tri_force = 1'b0, cnt_rst = 1'b0;
  logic up, dn, pump_en, lock;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit pu, pd, lk, rq, fq;
  int ov, w, g;

  always #4 clk = ~clk;

  pfd_lock_top #(.DLY(DLY), .WTH(WTH), .LOCK_N(LN)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .pol_pos(pol_pos), .tri_force(tri_force), .cnt_rst(cnt_rst),
    .up(up), .dn(dn), .pump_en(pump_en), .lock(lock)
  );

  always @(posedge clk) begin
    bit rr, fr, act, both, clr;
    if (!rst_n) begin
      pu = 0; pd = 0; lk = 0; rq = 0; fq = 0; ov = 0; w = 0; g = 0;
    end else begin
      rr = ref_in && !rq;
      fr = fb_in && !fq;
      rq = ref_in;
      fq = fb_in;
      act  = pu || pd;
      both = pu && pd;
      clr  = both && (ov == DLY - 1);
      if (cnt_rst) begin
        pu = 0; pd = 0; ov = 0; w = 0; g = 0; lk = 0;
      end else begin
        if (act && w >= WTH) begin
          g = 0; lk = 0;
        end else if (clr && w + 1 <= WTH) begin
          if (g < LN) g = g + 1;
          lk = (g >= LN);
        end
        if (clr) w = 0;
        else if (act) begin if (w < WTH + 1) w = w + 1; end
        else w = 0;
        if (clr) begin
          pu = 0; pd = 0; ov = 0;
        end else begin
          ov = both ? ov + 1 : 0;
          if (rr) pu = 1;
          if (fr) pd = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit off, eu, ed;
    off = tri_force || cnt_rst;
    eu  = !off && (pol_pos ? pu : pd);
    ed  = !off && (pol_pos ? pd : pu);
    chk("R1 up vs model", up, eu);
    chk("R2 dn vs model", dn, ed);
    chk("R5 pump_en vs model", pump_en, !off);
    chk("R8 lock vs model", lock, lk && !(pu || pd));
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic pair(input int lag, input bit ref_first);
    if (ref_first) ref_in = 1'b1; else fb_in = 1'b1;
    repeat (lag) tick();
    ref_in = 1'b1;
    fb_in  = 1'b1;
    repeat (DLY + 3) tick();
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (3) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    // R10 reset state
    chk("R10 up", up, 1'b0);
    chk("R10 dn", dn, 1'b0);
    chk("R10 lock", lock, 1'b0);
    chk("R10 pump_en", pump_en, 1'b1);
    rst_n = 1'b1;
    repeat (2) tick();

    // R1, R2, R3: reference leads by one cycle
    ref_in = 1'b1;
    tick();
    chk("R1 up set", up, 1'b1);
    chk("R1 dn idle", dn, 1'b0);
    fb_in = 1'b1;
    tick();
    chk("R2 dn set", dn, 1'b1);
    tick();
    chk("R3 overlap second cycle up", up, 1'b1);
    chk("R3 overlap second cycle dn", dn, 1'b1);
    tick();
    chk("R3 cleared up", up, 1'b0);
    chk("R3 cleared dn", dn, 1'b0);
    ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) tick();

    // R4 polarity exchanged
    pol_pos = 1'b0;
    ref_in = 1'b1;
    tick();
    chk("R4 ref drives dn", dn, 1'b1);
    chk("R4 up idle", up, 1'b0);
    fb_in = 1'b1;
    repeat (4) tick();
    ref_in = 1'b0; fb_in = 1'b0;
    pol_pos = 1'b1;
    repeat (2) tick();
    pair(1, 1'b0);

    // R5 three-state
    tri_force = 1'b1;
    ref_in = 1'b1;
    tick();
    chk("R5 up quiet", up, 1'b0);
    chk("R5 dn quiet", dn, 1'b0);
    chk("R5 pump off", pump_en, 1'b0);
    fb_in = 1'b1;
    repeat (4) tick();
    ref_in = 1'b0; fb_in = 1'b0; tri_force = 1'b0;
    tick();
    chk("R5 pump back", pump_en, 1'b1);
    chk("R5 up idle after", up, 1'b0);

    // R7 lock acquisition
    cnt_rst = 1'b1;
    tick();
    cnt_rst = 1'b0;
    tick();
    repeat (3) pair(0, 1'b1);
    chk("R7 no lock after three", lock, 1'b0);
    pair(0, 1'b0);
    chk("R7 lock after four", lock, 1'b1);
    pair(2, 1'b1);
    chk("R7 threshold width keeps lock", lock, 1'b1);

    // R8 low gap while locked
    ref_in = 1'b1; fb_in = 1'b1;
    tick();
    chk("R8 low during pulse", lock, 1'b0);
    repeat (3) tick();
    ref_in = 1'b0; fb_in = 1'b0;
    tick();
    chk("R8 high after pulse", lock, 1'b1);

    // R9 wide pulse drops lock
    pair(3, 1'b0);
    chk("R9 lock dropped", lock, 1'b0);

    // relock, then R6 counter reset
    repeat (4) pair(1, 1'b1);
    chk("R7 relocked", lock, 1'b1);
    cnt_rst = 1'b1;
    ref_in = 1'b1;
    tick();
    chk("R6 up quiet", up, 1'b0);
    chk("R6 pump off", pump_en, 1'b0);
    chk("R6 lock cleared", lock, 1'b0);
    cnt_rst = 1'b0;
    tick();
    chk("R6 edge not kept up", up, 1'b0);
    chk("R6 edge not kept dn", dn, 1'b0);
    chk("R6 lock stays clear", lock, 1'b0);
    ref_in = 1'b0;
    repeat (3) tick();
    finish_run();
  end
endmodule